// File: doc/BRIEF.md
# Write-Address Latched PRG Bank Mapper

This block is the banking logic of a discrete-logic game cartridge. It does not look at the CPU data bus. On every CPU write whose address falls in the upper half of the CPU space (0x8000 to 0xFFFF), the whole 16-bit write address is captured into a latch. The program ROM bank layout, an optional extra 8 KB ROM window at 0x6000 to 0x7FFF, and the nametable mirroring are then decoded from that latched address. The graphics bank is tied to zero.

Two PRG layouts exist. With latch bit 6 set, one 16 KB bank taken from latch bits 4:0 is shown in both halves of the 32 KB ROM window. With latch bit 6 clear, a 32 KB bank taken from latch bits 5:1 fills the whole window, and latch bit 11 then also opens an 8 KB ROM window at 0x6000 whose bank number is derived from the low latch bits. Beyond the bank numbers, the block translates every CPU address into a ROM byte address so that the ROM array can be driven directly.

Bank outputs are given in 16 KB units for the two halves of the ROM window (`prg_lo_bank` for 0x8000 to 0xBFFF, `prg_hi_bank` for 0xC000 to 0xFFFF) and in 8 KB units for the low window. All outputs are registered.

Top module: `addr_latch_mapper`

## Requirements
- R1: When `cpu_wr` is high at a rising clock edge and `cpu_addr[15]` is 1, the latch takes the whole of `cpu_addr`; the bank, window and mirroring outputs show the new latch from the second rising edge after that write. A write with `cpu_addr[15]` equal to 0 leaves every output unchanged.
- R2: Synchronous active-high `rst` sets the latch to 0x0000; the outputs then read `prg_lo_bank`=0, `prg_hi_bank`=1, `win_en`=0, `mirror_horiz`=0, `rom_hit`=0, `rom_addr`=0.
- R3: With latch bit 6 at 1 (16 KB layout), `prg_lo_bank` and `prg_hi_bank` both equal latch bits 4:0 (upper bit 0).
- R4: With latch bit 6 at 0 (32 KB layout), `prg_lo_bank` is {latch[5:1], 0} and `prg_hi_bank` is {latch[5:1], 1}.
- R5: `win_en` is 1 only when latch bit 6 is 0 and latch bit 11 is 1; `win_bank` is {latch[4:1], 1, 1}, i.e. ((latch << 1) & 0x3F) | 3.
- R6: `mirror_horiz` equals latch bit 7 (1 = horizontal arrangement, 0 = vertical).
- R7: `chr_bank` is 0 at all times.
- R8: One cycle after `cpu_addr[15]` is 1, `rom_hit` is 1 and `rom_addr` is {bank, cpu_addr[13:0]}, where bank is `prg_hi_bank`'s decoded value when `cpu_addr[14]` is 1 and `prg_lo_bank`'s otherwise.
- R9: One cycle after `cpu_addr[15:13]` is 3'b011 while the window is enabled, `rom_hit` is 1 and `rom_addr` is {0, window bank, cpu_addr[12:0]}; for any other address below 0x8000 `rom_hit` is 0 and `rom_addr` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_addr | input | 16 | CPU address bus |
| cpu_wr | input | 1 | CPU write strobe, one cycle per write |
| prg_lo_bank | output | 6 | 16 KB bank shown at 0x8000-0xBFFF |
| prg_hi_bank | output | 6 | 16 KB bank shown at 0xC000-0xFFFF |
| win_en | output | 1 | Extra 8 KB ROM window at 0x6000-0x7FFF is open |
| win_bank | output | 6 | 8 KB bank of that window |
| chr_bank | output | 8 | 8 KB graphics bank (always 0) |
| mirror_horiz | output | 1 | Nametable arrangement, 1 = horizontal |
| rom_addr | output | 20 | Translated ROM byte address |
| rom_hit | output | 1 | `rom_addr` selects ROM for the previous cycle's address |

## Verification
The properties assume `cpu_addr` and `cpu_wr` are driven to known values from time zero and that reset is held for at least two clocks, so that the two-cycle write-to-output path has settled before the hold property looks back. They also assume a write strobe lasts a single cycle per access; the stimulus drives every input at the falling edge, pulses `cpu_wr` for exactly one cycle, and leaves at least two idle cycles after each write before comparing the bank outputs. Random addresses cover both halves of the CPU space so that ignored low writes and window reads are mixed with latch updates.

// File: rtl/alb_pkg.sv
package alb_pkg;
  // Latch bit that picks the 16 KB layout.
  localparam int MODE16_BIT = 6;
  // Latch bit that picks horizontal nametable arrangement.
  localparam int MIRROR_BIT = 7;
  // Latch bit that opens the low 8 KB ROM window (32 KB layout only).
  localparam int WIN_BIT    = 11;
  // Offset bits inside a 16 KB and an 8 KB page.
  localparam int PAGE16_OFS = 14;
  localparam int PAGE8_OFS  = 13;

  typedef enum logic {
    PRG_32K = 1'b0,
    PRG_16K = 1'b1
  } prg_mode_e;
endpackage

// File: rtl/alb_latch.sv
module alb_latch #(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr,
  input  logic [AW-1:0] addr,
  output logic [AW-1:0] latch_q
);
  // Only writes into the upper half of the CPU space reach the latch.
  logic hit_upper;
  assign hit_upper = wr & addr[AW-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      latch_q <= '0;
    end else if (hit_upper) begin
      latch_q <= addr;
    end
  end
endmodule

// File: rtl/alb_decode.sv
module alb_decode
  import alb_pkg::*;
#(
  parameter int AW     = 16,
  parameter int BANK_W = 6,
  parameter int WIN_W  = 6
) (
  input  logic [AW-1:0]     latch_i,
  output prg_mode_e         mode_o,
  output logic [BANK_W-1:0] lo_bank_o,
  output logic [BANK_W-1:0] hi_bank_o,
  output logic              win_en_o,
  output logic [WIN_W-1:0]  win_bank_o,
  output logic              mirror_o
);
  logic [BANK_W-1:0] bank16;
  logic [BANK_W-2:0] bank32;

  assign mode_o = latch_i[MODE16_BIT] ? PRG_16K : PRG_32K;
  // 16 KB number uses one bit fewer than the output width.
  assign bank16 = {1'b0, latch_i[BANK_W-2:0]};
  // 32 KB number drops latch bit 0.
  assign bank32 = latch_i[BANK_W-1:1];

  always_comb begin
    if (mode_o == PRG_16K) begin
      lo_bank_o = bank16;
      hi_bank_o = bank16;
    end else begin
      lo_bank_o = {bank32, 1'b0};
      hi_bank_o = {bank32, 1'b1};
    end
  end

  assign win_en_o   = (mode_o == PRG_32K) & latch_i[WIN_BIT];
  assign win_bank_o = {latch_i[WIN_W-2:1], 2'b11};
  assign mirror_o   = latch_i[MIRROR_BIT];
endmodule

// File: rtl/alb_xlate.sv
module alb_xlate
  import alb_pkg::*;
#(
  parameter int AW     = 16,
  parameter int BANK_W = 6,
  parameter int WIN_W  = 6,
  parameter int ROM_AW = BANK_W + PAGE16_OFS
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [AW-1:0]     addr,
  input  logic [BANK_W-1:0] lo_bank,
  input  logic [BANK_W-1:0] hi_bank,
  input  logic              win_en,
  input  logic [WIN_W-1:0]  win_bank,
  output logic [ROM_AW-1:0] rom_addr_q,
  output logic              rom_hit_q
);
  localparam logic [2:0] LOW_WIN_TAG = 3'b011;

  logic              in_upper;
  logic              in_window;
  logic [BANK_W-1:0] half_bank;
  logic [ROM_AW-1:0] rom_addr_d;
  logic              rom_hit_d;

  assign in_upper  = addr[AW-1];
  assign in_window = (addr[AW-1:AW-3] == LOW_WIN_TAG) & win_en;
  assign half_bank = addr[PAGE16_OFS] ? hi_bank : lo_bank;

  always_comb begin
    rom_addr_d = '0;
    rom_hit_d  = 1'b0;
    if (in_upper) begin
      rom_addr_d = {half_bank, addr[PAGE16_OFS-1:0]};
      rom_hit_d  = 1'b1;
    end else if (in_window) begin
      rom_addr_d = ROM_AW'({win_bank, addr[PAGE8_OFS-1:0]});
      rom_hit_d  = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rom_addr_q <= '0;
      rom_hit_q  <= 1'b0;
    end else begin
      rom_addr_q <= rom_addr_d;
      rom_hit_q  <= rom_hit_d;
    end
  end
endmodule

// File: rtl/addr_latch_mapper.sv
module addr_latch_mapper
  import alb_pkg::*;
#(
  parameter int CPU_AW = 16,
  parameter int BANK_W = 6,
  parameter int WIN_W  = 6,
  parameter int CHR_W  = 8,
  parameter int ROM_AW = BANK_W + 14
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CPU_AW-1:0] cpu_addr,
  input  logic              cpu_wr,
  output logic [BANK_W-1:0] prg_lo_bank,
  output logic [BANK_W-1:0] prg_hi_bank,
  output logic              win_en,
  output logic [WIN_W-1:0]  win_bank,
  output logic [CHR_W-1:0]  chr_bank,
  output logic              mirror_horiz,
  output logic [ROM_AW-1:0] rom_addr,
  output logic              rom_hit
);
  localparam logic [BANK_W-1:0] RST_LO = '0;
  localparam logic [BANK_W-1:0] RST_HI = BANK_W'(1);
  localparam logic [WIN_W-1:0]  RST_WB = WIN_W'(3);

  logic [CPU_AW-1:0] latch_q;
  prg_mode_e         mode_c;
  logic [BANK_W-1:0] lo_c, hi_c;
  logic              win_en_c;
  logic [WIN_W-1:0]  win_bank_c;
  logic              mirror_c;

  alb_latch #(.AW(CPU_AW)) u_latch (
    .clk     (clk),
    .rst     (rst),
    .wr      (cpu_wr),
    .addr    (cpu_addr),
    .latch_q (latch_q)
  );

  alb_decode #(.AW(CPU_AW), .BANK_W(BANK_W), .WIN_W(WIN_W)) u_dec (
    .latch_i    (latch_q),
    .mode_o     (mode_c),
    .lo_bank_o  (lo_c),
    .hi_bank_o  (hi_c),
    .win_en_o   (win_en_c),
    .win_bank_o (win_bank_c),
    .mirror_o   (mirror_c)
  );

  alb_xlate #(.AW(CPU_AW), .BANK_W(BANK_W), .WIN_W(WIN_W), .ROM_AW(ROM_AW)) u_xlate (
    .clk        (clk),
    .rst        (rst),
    .addr       (cpu_addr),
    .lo_bank    (lo_c),
    .hi_bank    (hi_c),
    .win_en     (win_en_c),
    .win_bank   (win_bank_c),
    .rom_addr_q (rom_addr),
    .rom_hit_q  (rom_hit)
  );

  // Output register stage; reset values equal the decode of an empty latch.
  always_ff @(posedge clk) begin
    if (rst) begin
      prg_lo_bank  <= RST_LO;
      prg_hi_bank  <= RST_HI;
      win_en       <= 1'b0;
      win_bank     <= RST_WB;
      chr_bank     <= '0;
      mirror_horiz <= 1'b0;
    end else begin
      prg_lo_bank  <= lo_c;
      prg_hi_bank  <= hi_c;
      win_en       <= win_en_c;
      win_bank     <= win_bank_c;
      chr_bank     <= '0;
      mirror_horiz <= mirror_c;
    end
  end
endmodule

// File: rtl/addr_latch_mapper_chk.sv
module addr_latch_mapper_chk #(
  parameter int CPU_AW = 16,
  parameter int BANK_W = 6,
  parameter int WIN_W  = 6,
  parameter int CHR_W  = 8,
  parameter int ROM_AW = BANK_W + 14
) (
  input logic              clk,
  input logic              rst,
  input logic [CPU_AW-1:0] cpu_addr,
  input logic              cpu_wr,
  input logic [BANK_W-1:0] prg_lo_bank,
  input logic [BANK_W-1:0] prg_hi_bank,
  input logic              win_en,
  input logic [WIN_W-1:0]  win_bank,
  input logic [CHR_W-1:0]  chr_bank,
  input logic              mirror_horiz,
  input logic [ROM_AW-1:0] rom_addr,
  input logic              rom_hit
);
  logic upper_wr;
  assign upper_wr = cpu_wr & cpu_addr[CPU_AW-1];

  // R1: with no upper write two cycles back, the decoded state holds.
  p_hold_without_write_r1: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(rst, 2) && !$past(upper_wr, 2))
      |-> $stable({prg_lo_bank, prg_hi_bank, win_en, win_bank, mirror_horiz}));

  // R2: the cycle after reset shows the empty-latch layout.
  p_reset_layout_r2: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (prg_lo_bank == '0 && prg_hi_bank == BANK_W'(1)
                    && !win_en && !mirror_horiz && !rom_hit));

  // R4: differing halves always form an even/odd pair of one 32 KB bank.
  p_pair_halves_r4: assert property (@(posedge clk) disable iff (rst)
    (prg_lo_bank != prg_hi_bank)
      |-> (!prg_lo_bank[0] && prg_hi_bank == (prg_lo_bank | BANK_W'(1))));

  // R5: an open window implies 32 KB layout and low bits 2'b11.
  p_window_shape_r5: assert property (@(posedge clk) disable iff (rst)
    win_en |-> (win_bank[1:0] == 2'b11 && prg_lo_bank != prg_hi_bank));

  // R7: the graphics bank never leaves zero.
  p_chr_fixed_r7: assert property (@(posedge clk) disable iff (rst)
    $past(cpu_wr) |-> (chr_bank == '0));

  // R8: an upper-half address is translated one cycle later.
  p_upper_read_r8: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(cpu_addr[CPU_AW-1]))
      |-> (rom_hit && rom_addr[13:0] == $past(cpu_addr[13:0])));

  // R9: addresses below the window never hit ROM.
  p_low_miss_r9: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(cpu_addr[CPU_AW-1:CPU_AW-3]) < 3'd3)
      |-> (!rom_hit && rom_addr == '0));
endmodule

bind addr_latch_mapper addr_latch_mapper_chk #(
  .CPU_AW(CPU_AW), .BANK_W(BANK_W), .WIN_W(WIN_W), .CHR_W(CHR_W), .ROM_AW(ROM_AW)
) u_chk (
  .clk          (clk),
  .rst          (rst),
  .cpu_addr     (cpu_addr),
  .cpu_wr       (cpu_wr),
  .prg_lo_bank  (prg_lo_bank),
  .prg_hi_bank  (prg_hi_bank),
  .win_en       (win_en),
  .win_bank     (win_bank),
  .chr_bank     (chr_bank),
  .mirror_horiz (mirror_horiz),
  .rom_addr     (rom_addr),
  .rom_hit      (rom_hit)
);

// File: tb/addr_latch_mapper_tb_top.sv
module addr_latch_mapper_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] cpu_addr = '0;
  logic        cpu_wr = 1'b0;
  logic [5:0]  prg_lo_bank, prg_hi_bank, win_bank;
  logic        win_en, mirror_horiz, rom_hit;
  logic [7:0]  chr_bank;
  logic [19:0] rom_addr;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;
  logic [15:0] shadow = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  addr_latch_mapper dut_i (
    .clk(clk), .rst(rst), .cpu_addr(cpu_addr), .cpu_wr(cpu_wr),
    .prg_lo_bank(prg_lo_bank), .prg_hi_bank(prg_hi_bank),
    .win_en(win_en), .win_bank(win_bank), .chr_bank(chr_bank),
    .mirror_horiz(mirror_horiz), .rom_addr(rom_addr), .rom_hit(rom_hit)
  );

  // Expected values derived from the requirements.
  function automatic logic [5:0] f_lo(input logic [15:0] l);
    return l[6] ? {1'b0, l[4:0]} : {l[5:1], 1'b0};
  endfunction
  function automatic logic [5:0] f_hi(input logic [15:0] l);
    return l[6] ? {1'b0, l[4:0]} : {l[5:1], 1'b1};
  endfunction
  function automatic logic f_wen(input logic [15:0] l);
    return !l[6] && l[11];
  endfunction
  function automatic logic [5:0] f_wbank(input logic [15:0] l);
    return 6'(((32'(l) << 1) & 32'h3F) | 32'h3);
  endfunction
  function automatic logic [20:0] f_rom(input logic [15:0] l, input logic [15:0] a);
    if (a[15])
      return {1'b1, (a[14] ? f_hi(l) : f_lo(l)), a[13:0]};
    else if (a[15:13] == 3'b011 && f_wen(l))
      return {1'b1, 1'b0, f_wbank(l), a[12:0]};
    else
      return '0;
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic cycle_write(input logic [15:0] a, input logic w);
    @(negedge clk);
    cpu_addr = a;
    cpu_wr   = w;
    if (w && a[15]) shadow = a;
    @(negedge clk);
    cpu_wr = 1'b0;
    @(negedge clk);
  endtask

  task automatic check_state(input string ctx);
    chk(prg_lo_bank == f_lo(shadow), {ctx, " R3/R4 lo"}, prg_lo_bank, f_lo(shadow));
    chk(prg_hi_bank == f_hi(shadow), {ctx, " R3/R4 hi"}, prg_hi_bank, f_hi(shadow));
    chk(win_en == f_wen(shadow), {ctx, " R5 win_en"}, win_en, f_wen(shadow));
    if (f_wen(shadow))
      chk(win_bank == f_wbank(shadow), {ctx, " R5 win_bank"}, win_bank, f_wbank(shadow));
    chk(mirror_horiz == shadow[7], {ctx, " R6 mirror"}, mirror_horiz, shadow[7]);
    chk(chr_bank == 8'h00, {ctx, " R7 chr"}, chr_bank, 0);
  endtask

  task automatic check_read(input logic [15:0] a, input string ctx);
    logic [20:0] e;
    @(negedge clk);
    cpu_addr = a;
    cpu_wr   = 1'b0;
    @(negedge clk);
    e = f_rom(shadow, a);
    chk(rom_hit == e[20], {ctx, " R8/R9 hit"}, rom_hit, e[20]);
    chk(rom_addr == e[19:0], {ctx, " R8/R9 addr"}, rom_addr, e[19:0]);
  endtask

  initial begin
    void'($urandom(32'h5EED_2282));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R2: reset layout.
    chk(prg_lo_bank == 0 && prg_hi_bank == 1, "R2 reset banks", {prg_lo_bank, prg_hi_bank}, 1);
    chk(!win_en && !mirror_horiz && !rom_hit && rom_addr == 0, "R2 reset flags",
        {win_en, mirror_horiz, rom_hit}, 0);
    check_state("R2");

    // R3: 16 KB layout, bank 0x1F, mirrored halves.
    cycle_write(16'h805F, 1'b1);
    check_state("R3 16k");
    check_read(16'hC123, "R3 hi half");
    check_read(16'h8ABC, "R3 lo half");

    // R4 + R5 + R6: 32 KB layout with window and horizontal arrangement.
    cycle_write(16'h08BE | 16'h8000, 1'b1);
    check_state("R4/R5/R6");
    check_read(16'h6001, "R9 window");
    check_read(16'h7FFF, "R9 window top");
    check_read(16'hFFFF, "R8 top");

    // R5: bit 11 in 16 KB layout keeps the window shut.
    cycle_write(16'h8840, 1'b1);
    check_state("R5 16k+bit11");
    check_read(16'h6800, "R9 window closed");

    // R1: low write is ignored.
    cycle_write(16'h7F3A, 1'b1);
    check_state("R1 low write ignored");
    check_read(16'h5FFF, "R9 below window");

    // R2: reset mid-run returns to the empty latch.
    cycle_write(16'hFFFF, 1'b1);
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    shadow = '0;
    @(negedge clk);
    check_state("R2 rerun");
    chk(prg_hi_bank == 1, "R2 rerun hi", prg_hi_bank, 1);

    // Random mix.
    for (int i = 0; i < 400; i++) begin
      logic [15:0] a;
      a = 16'($urandom);
      if ((i % 7) == 0) a[15] = 1'b0;
      cycle_write(a, ($urandom % 4) != 0);
      check_state("R1 random");
      check_read(16'($urandom), "R8/R9 random");
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule